// File: doc/BRIEF.md
# OTG Event Status and Interrupt Register

This block is one 32-bit register of a USB On-The-Go port controller. It watches the raw OTG event sources and records each event in a sticky status bit. The sources are the ID pin level, the B-session-end, B-session-valid and A-session-valid levels, the A-device VBUS-valid level, pulses on the D+/D- data lines, and a built-in one-millisecond tick. Software reads the status bits and clears each one by writing 1 to it. Every source has its own enable bit. The single interrupt line is high while any enabled source has pending status.

The level inputs are asynchronous. Each passes through a two-flop synchronizer. Any change of the synchronized level, in either direction, counts as an event. Data-line pulses count only while the controller runs in host mode (mode field 2'b11) with port power off. A live, non-latched view of the qualified pulse detector is also readable. The millisecond tick comes from a free-running counter on the 60 MHz PHY-side clock, which also clocks the whole register.

Top module: `otg_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x0000_0000 and `irq` is low.
- R2: Bits 30:24 are read/write enables, one per source: bit 30 data pulse, 29 ms tick, 28 B session end, 27 B session valid, 26 A session valid, 25 VBUS valid, 24 ID. Bits 31, 23 and 15 and every bit below 14 read zero, and writes to them are ignored.
- R3: Status bits 22:16 use the same source order as the enables (22 data pulse, 21 ms tick, 20 B session end, 19 B session valid, 18 A session valid, 17 VBUS valid, 16 ID). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R4: A change of a level input in either direction sets that source's status bit. The bit becomes visible after the third rising clock edge following the change.
- R5: A high level on `dp_pulse` or `dm_pulse` sets status bit 22 at the next edge, but only while `ctrl_mode` is 2'b11 and `port_pwr` is 0. In any other mode or power state the pulse is ignored.
- R6: Bit 14 reads the qualified pulse detector without latching. It follows the inputs in the same cycle and drops when the pulse ends.
- R7: Status bit 21 sets once every `TICK_CYCLES` (60,000) clock cycles. The first tick is seen after edge 60,000 following reset release.
- R8: `irq` is high while any status bit and its enable are both set. It stays high until software clears the pending bits or their enables.
- R9: When a hardware event and a write-1 clear reach the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz PHY-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| id_lvl | input | 1 | ID pin level (async) |
| vbus_vld | input | 1 | A-device VBUS valid level (async) |
| a_sess_vld | input | 1 | A session valid level (async) |
| b_sess_vld | input | 1 | B session valid level (async) |
| b_sess_end | input | 1 | B session end level (async) |
| dp_pulse | input | 1 | D+ pulse detector output |
| dm_pulse | input | 1 | D- pulse detector output |
| ctrl_mode | input | 2 | Controller mode, 2'b11 = host |
| port_pwr | input | 1 | Port power on |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that the pulse inputs, mode and port power are synchronous to `clk`, and that the level inputs stay stable long enough to cross both synchronizer flops. The stimulus changes every input on the falling edge and holds each level for several cycles. It also keeps all inputs low through reset, so a level that is high at reset cannot be mistaken for a change. The set-over-clear property relies on a write and a qualified pulse arriving in the same cycle, and the bench builds exactly that case.

// File: rtl/otg_irq_pkg.sv
package otg_irq_pkg;
  localparam int unsigned NSRC = 7;
  // source indices, shared by enable (24+i) and status (16+i) positions
  localparam int unsigned S_ID  = 0;
  localparam int unsigned S_AVV = 1;
  localparam int unsigned S_ASV = 2;
  localparam int unsigned S_BSV = 3;
  localparam int unsigned S_BSE = 4;
  localparam int unsigned S_TMR = 5;
  localparam int unsigned S_DP  = 6;
  localparam int unsigned EN_LSB   = 24;
  localparam int unsigned ST_LSB   = 16;
  localparam int unsigned LIVE_BIT = 14;

  typedef logic [NSRC-1:0] src_vec_t;

  function automatic src_vec_t next_status(src_vec_t cur, src_vec_t set, src_vec_t clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [31:0] pack_csr(src_vec_t en, src_vec_t st, logic live);
    logic [31:0] r;
    r = '0;
    r[EN_LSB +: NSRC] = en;
    r[ST_LSB +: NSRC] = st;
    r[LIVE_BIT]       = live;
    return r;
  endfunction
endpackage

// File: rtl/otg_level_watch.sv
module otg_level_watch #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_async,
  output logic [W-1:0] lvl_chg
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q[i]   <= 1'b0;
        s2_q[i]   <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        s1_q[i]   <= lvl_async[i];
        s2_q[i]   <= s1_q[i];
        prev_q[i] <= s2_q[i];
      end
    end
    assign lvl_chg[i] = s2_q[i] ^ prev_q[i];

    // R4: after a change the registered copy tracks the synchronized level
    p_change_tracked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_chg[i] |=> (prev_q[i] == $past(s2_q[i])));
  end
endmodule

// File: rtl/otg_tick_timer.sv
module otg_tick_timer #(
  parameter int unsigned TICK_CYCLES = 60000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = $clog2(TICK_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
  p_tick_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/otg_sticky_status.sv
module otg_sticky_status
  import otg_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  src_vec_t clr_vec,
  output src_vec_t st_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= next_status(st_q, set_vec, clr_vec);
  end

  // R9: a hardware set always lands, even against a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((st_q & $past(set_vec)) == $past(set_vec)));
  // R3: a clear without a competing set empties the bit
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((st_q & $past(clr_vec & ~set_vec)) == '0));
  // R3: bits neither set nor cleared keep their value
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(set_vec | clr_vec)) == ($past(st_q) & ~$past(set_vec | clr_vec))));
endmodule

// File: rtl/otg_irq_ctrl.sv
module otg_irq_ctrl
  import otg_irq_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 60000,
  parameter logic [1:0]  HOST_MODE   = 2'b11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        id_lvl,
  input  logic        vbus_vld,
  input  logic        a_sess_vld,
  input  logic        b_sess_vld,
  input  logic        b_sess_end,
  input  logic        dp_pulse,
  input  logic        dm_pulse,
  input  logic [1:0]  ctrl_mode,
  input  logic        port_pwr,
  output logic        irq
);
  localparam int unsigned NLVL = 5;

  logic [NLVL-1:0] lvl_raw, lvl_chg;
  logic            ms_tick;
  logic            pulse_live;
  logic            pulse_gate;
  src_vec_t        en_q, st_q, set_vec, clr_vec;
  logic            unused_wr;

  // level inputs ordered to match source indices 0..4
  assign lvl_raw = {b_sess_end, b_sess_vld, a_sess_vld, vbus_vld, id_lvl};

  otg_level_watch #(.W(NLVL)) u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_async (lvl_raw),
    .lvl_chg   (lvl_chg)
  );

  otg_tick_timer #(.TICK_CYCLES(TICK_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (ms_tick)
  );

  assign pulse_gate = (ctrl_mode == HOST_MODE) && !port_pwr;
  assign pulse_live = pulse_gate && (dp_pulse || dm_pulse);

  assign set_vec = {pulse_live, ms_tick, lvl_chg};
  assign clr_vec = wr_en ? wr_data[ST_LSB +: NSRC] : '0;

  otg_sticky_status u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .st_q    (st_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_data[EN_LSB +: NSRC];
  end

  assign unused_wr = ^{wr_data[31], wr_data[23], wr_data[15:0]};

  assign rd_data = pack_csr(en_q, st_q, pulse_live);
  assign irq     = |(st_q & en_q);

  // R5: outside host mode with power off no pulse reaches the status
  p_pulse_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_mode != HOST_MODE || port_pwr) |-> !pulse_live);
  // R8: the interrupt level holds while software leaves the register alone
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> irq);
  // R6: the live pulse bit never latches
  p_live_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_pulse || dm_pulse) |-> !rd_data[LIVE_BIT]);
endmodule

// File: tb/otg_irq_ctrl_bench.sv
module otg_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 60000;
  localparam int NVEC = 7;
  // {write value, expected value of bits 31:23}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'hFF80_0000, 32'h7F00_0000},
    {32'h0000_0000, 32'h0000_0000},
    {32'h4000_0000, 32'h4000_0000},
    {32'h0100_0000, 32'h0100_0000},
    {32'h2A80_0000, 32'h2A00_0000},
    {32'h5500_0000, 32'h5500_0000},
    {32'h8080_0000, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic id_lvl = 1'b0, vbus_vld = 1'b0, a_sess_vld = 1'b0, b_sess_vld = 1'b0, b_sess_end = 1'b0;
  logic dp_pulse = 1'b0, dm_pulse = 1'b0;
  logic [1:0] ctrl_mode = 2'b00;
  logic port_pwr = 1'b0;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otg_irq_ctrl u_otg_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .id_lvl(id_lvl), .vbus_vld(vbus_vld), .a_sess_vld(a_sess_vld),
    .b_sess_vld(b_sess_vld), .b_sess_end(b_sess_end), .dp_pulse(dp_pulse),
    .dm_pulse(dm_pulse), .ctrl_mode(ctrl_mode), .port_pwr(port_pwr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset read", rd_data, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: first tick after edge 60000
    edges(TICKS - 1);
    chk("R7 before tick", {31'b0, rd_data[21]}, 32'h0);
    edges(1);
    chk("R7 tick status", {31'b0, rd_data[21]}, 32'h1);

    // R2: enable field through the vector table
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][63:32]);
      chk("R2 enable table", rd_data & 32'hFF80_0000, VEC[k][31:0]);
    end

    // R8: ms tick pending with its enable
    wr(32'h2000_0000);
    chk("R8 irq on", {31'b0, irq}, 32'h1);
    edges(5);
    chk("R8 irq held", {31'b0, irq}, 32'h1);
    wr(32'h1F00_0000);
    chk("R8 irq off without enable", {31'b0, irq}, 32'h0);
    // R3: clear ms status
    wr(32'h2020_0000);
    chk("R3 clear tick", {31'b0, rd_data[21]}, 32'h0);
    chk("R8 irq after clear", {31'b0, irq}, 32'h0);

    // R4: ID rising edge, visible after third edge
    @(negedge clk); id_lvl = 1'b1;
    edges(2);
    chk("R4 id not yet", {31'b0, rd_data[16]}, 32'h0);
    edges(1);
    chk("R4 id rise", {31'b0, rd_data[16]}, 32'h1);
    chk("R8 id irq", {31'b0, irq}, 32'h0);
    wr(32'h2100_0000);
    chk("R8 id irq enabled", {31'b0, irq}, 32'h1);
    // R3: writing zero keeps the status
    wr(32'h2100_0000);
    chk("R3 zero write keeps", {31'b0, rd_data[16]}, 32'h1);
    wr(32'h2101_0000);
    chk("R3 clear id", {31'b0, rd_data[16]}, 32'h0);
    @(negedge clk); id_lvl = 1'b0;
    edges(3);
    chk("R4 id fall", {31'b0, rd_data[16]}, 32'h1);
    // R4: VBUS valid and B session end
    @(negedge clk); vbus_vld = 1'b1; b_sess_end = 1'b1;
    edges(3);
    chk("R4 vbus and bse", rd_data[22:16] & 7'h12, 32'h12);
    wr(32'h007F_0000);
    chk("R3 clear all status", {25'b0, rd_data[22:16]}, 32'h0);

    // R5 / R6: qualified pulse in host mode, power off
    @(negedge clk); ctrl_mode = 2'b11; port_pwr = 1'b0; dp_pulse = 1'b1;
    #1;
    chk("R6 live high", {31'b0, rd_data[14]}, 32'h1);
    chk("R5 not yet latched", {31'b0, rd_data[22]}, 32'h0);
    edges(1);
    chk("R5 dp latched", {31'b0, rd_data[22]}, 32'h1);
    @(negedge clk); dp_pulse = 1'b0;
    #1;
    chk("R6 live drops", {31'b0, rd_data[14]}, 32'h0);
    chk("R5 status sticky", {31'b0, rd_data[22]}, 32'h1);
    wr(32'h0040_0000);
    // R5: device mode ignores pulses
    @(negedge clk); ctrl_mode = 2'b10; dm_pulse = 1'b1;
    edges(2);
    chk("R5 device mode ignored", {17'b0, rd_data[22], 7'b0, rd_data[14], 6'b0}, 32'h0);
    // R5: host mode with power on ignores pulses
    @(negedge clk); ctrl_mode = 2'b11; port_pwr = 1'b1;
    edges(2);
    chk("R5 power on ignored", {17'b0, rd_data[22], 7'b0, rd_data[14], 6'b0}, 32'h0);
    // R5: D- pulse qualifies with power off
    @(negedge clk); port_pwr = 1'b0;
    edges(1);
    chk("R5 dm latched", {31'b0, rd_data[22]}, 32'h1);
    // R9: clear in the same cycle as a held pulse
    wr(32'h4040_0000);
    chk("R9 set beats clear", {31'b0, rd_data[22]}, 32'h1);
    chk("R8 dp irq", {31'b0, irq}, 32'h1);
    @(negedge clk); dm_pulse = 1'b0;
    wr(32'h4040_0000);
    chk("R9 clear after pulse", {31'b0, rd_data[22]}, 32'h0);
    chk("R8 irq released", {31'b0, irq}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule